// File: doc/BRIEF.md
# Memory Channel Index Hasher

This block sits after the address splitter of a memory system and re-derives which memory channel a request goes to. It receives a request that has already been split into a channel index, a DRAM row and a bank number. It replaces the channel index with the result of one of several XOR interleaving functions of the row and bank bits. Regular strides that would otherwise pile onto one channel are then spread across all partitions.

From the final channel and the low bank bits it also forms a sub-partition identifier. It raises an error flag when the selected function cannot be used or would give an out-of-range channel. In that case the original channel is forwarded unchanged. Every result is registered once and qualified by a valid strobe.

Top module: `chan_hash_unit`

## Requirements
- R1: While reset is asserted (rst_n low), valid_o, err_o, chan_o and subp_o are all zero.
- R2: valid_o is high exactly in the cycle after a cycle with valid_i high, and err_o is only ever high together with valid_o.
- R3: Mode code 0 (straight) and mode code 3 (user slot) forward chan_i unchanged when it is below NUM_CHAN.
- R4: Mode code 1 (stripe XOR) gives chan_i XOR (row_i AND (NUM_CHAN-1)).
- R5: Mode code 2 (polynomial) flips output bit k of chan_i by the XOR parity of row_i bits: k=0 {0,3,5,6,9,10,11,12,13}; k=1 {1,4,6,7,10,11,12,13,14}; k=2 {0,2,3,6,7,8,9,10,14}; k=3 {1,3,4,7,8,9,10,11}; k=4 {2,4,5,8,9,10,11,12}.
- R6: Mode code 2 with NUM_CHAN other than 32 sets err_o and forwards chan_i unchanged.
- R7: Mode code 4 (entropy) flips output bit k of chan_i by the parity of these row_i bits and bank_i bits: k=0 row {0,5,9,10,13}, bank {0,3}; k=1 row {1,6,11,12}, bank {1,2,3}; k=2 row {2,7,8,9,14}, bank {1}; k=3 row {3,8,10,11}, bank {2,3}; k=4 row {4,5,8,9,12}, bank {0,1}.
- R8: Mode codes 5, 6 and 7 set err_o and forward chan_i unchanged.
- R9: When a mode would produce a channel greater than or equal to NUM_CHAN, err_o is set and chan_i is forwarded unchanged, so that without err_o chan_o is always below NUM_CHAN.
- R10: subp_o equals chan_o times SUBP_PER_CHAN plus (bank_i AND (SUBP_PER_CHAN-1)).
- R11: While valid_i is low, chan_o and subp_o keep their last values and err_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Hash function select (codes in R3 to R8) |
| chan_i | input | 5 | Channel index before hashing |
| row_i | input | ROW_W (15) | DRAM row |
| bank_i | input | BANK_W (4) | DRAM bank |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| chan_o | output | 5 | Final channel index |
| subp_o | output | 5+log2(SUBP_PER_CHAN) (6) | Sub-partition identifier |
| err_o | output | 1 | Function unusable or channel out of range |

## Verification
Each request goes to two instances at once, one with 32 channels and one with 16. This shows apart the function-availability error, the range error and the normal hashed result. The polynomial and entropy functions get rows with a single bit set, one at bit 14 and one at bit 0, so a wrong or missing tap shows up as a single flipped channel bit. The bank-only entropy case isolates the bank taps. Dense random-looking rows exercise all taps together. The stripe mode uses rows whose bits lie above the channel mask, which shows whether the mask depends on the channel count. Straight mode with a channel index above 15 separates forwarding from the range check.

// File: rtl/chan_hash_pkg.sv
package chan_hash_pkg;

  localparam int CH_W = 5;
  localparam int HASH_ROW_MIN = 15;
  localparam int HASH_BANK_W = 4;

  typedef enum logic [2:0] {
    HM_STRAIGHT = 3'd0,
    HM_STRIPE   = 3'd1,
    HM_POLY     = 3'd2,
    HM_USER     = 3'd3,
    HM_ENTROPY  = 3'd4
  } hash_mode_e;

  // Polynomial interleave: each channel bit folded with a fixed row tap set.
  function automatic logic [CH_W-1:0] poly_fold(
    input logic [CH_W-1:0]          c,
    input logic [HASH_ROW_MIN-1:0]  a
  );
    logic [CH_W-1:0] r;
    r[0] = c[0] ^ a[0] ^ a[3] ^ a[5] ^ a[6] ^ a[9] ^ a[10] ^ a[11] ^ a[12] ^ a[13];
    r[1] = c[1] ^ a[1] ^ a[4] ^ a[6] ^ a[7] ^ a[10] ^ a[11] ^ a[12] ^ a[13] ^ a[14];
    r[2] = c[2] ^ a[0] ^ a[2] ^ a[3] ^ a[6] ^ a[7] ^ a[8] ^ a[9] ^ a[10] ^ a[14];
    r[3] = c[3] ^ a[1] ^ a[3] ^ a[4] ^ a[7] ^ a[8] ^ a[9] ^ a[10] ^ a[11];
    r[4] = c[4] ^ a[2] ^ a[4] ^ a[5] ^ a[8] ^ a[9] ^ a[10] ^ a[11] ^ a[12];
    return r;
  endfunction

  // Entropy interleave: row and bank taps folded into each channel bit.
  function automatic logic [CH_W-1:0] entropy_fold(
    input logic [CH_W-1:0]          c,
    input logic [HASH_ROW_MIN-1:0]  a,
    input logic [HASH_BANK_W-1:0]   b
  );
    logic [CH_W-1:0] r;
    r[0] = c[0] ^ a[0] ^ a[5] ^ a[9] ^ a[10] ^ a[13] ^ b[0] ^ b[3];
    r[1] = c[1] ^ a[1] ^ a[6] ^ a[11] ^ a[12] ^ b[1] ^ b[2] ^ b[3];
    r[2] = c[2] ^ a[2] ^ a[7] ^ a[8] ^ a[9] ^ a[14] ^ b[1];
    r[3] = c[3] ^ a[3] ^ a[8] ^ a[10] ^ a[11] ^ b[2] ^ b[3];
    r[4] = c[4] ^ a[4] ^ a[5] ^ a[8] ^ a[9] ^ a[12] ^ b[0] ^ b[1];
    return r;
  endfunction

  // Stripe permutation: low row bits masked by the channel count.
  function automatic logic [CH_W-1:0] stripe_fold(
    input logic [CH_W-1:0] c,
    input logic [CH_W-1:0] low_row,
    input logic [CH_W-1:0] mask
  );
    return c ^ (low_row & mask);
  endfunction

endpackage

// File: rtl/chan_hash_mix.sv
module chan_hash_mix
  import chan_hash_pkg::*;
#(
  parameter int NUM_CHAN = 32,
  parameter int ROW_W    = 15,
  parameter int BANK_W   = 4
) (
  input  logic [2:0]        mode_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [CH_W-1:0]   chan_o,
  output logic              mode_err_o,
  output logic              range_err_o
);

  localparam logic [CH_W-1:0] CHAN_MASK = CH_W'(NUM_CHAN - 1);
  localparam logic [CH_W:0]   CHAN_LIM  = (CH_W+1)'(NUM_CHAN);

  logic [CH_W-1:0] cand;
  logic [CH_W-1:0] poly_res;
  logic            poly_ok;
  logic            mode_bad;

  // The polynomial function exists only for a 32-channel system.
  generate
    if (NUM_CHAN == 32) begin : g_poly
      assign poly_res = poly_fold(chan_i, row_i[HASH_ROW_MIN-1:0]);
      assign poly_ok  = 1'b1;
    end else begin : g_no_poly
      assign poly_res = chan_i;
      assign poly_ok  = 1'b0;
    end
  endgenerate

  always_comb begin
    cand     = chan_i;
    mode_bad = 1'b0;
    case (hash_mode_e'(mode_i))
      HM_STRAIGHT, HM_USER: cand = chan_i;
      HM_STRIPE:   cand = stripe_fold(chan_i, row_i[CH_W-1:0], CHAN_MASK);
      HM_POLY: begin
        cand     = poly_res;
        mode_bad = !poly_ok;
      end
      HM_ENTROPY:  cand = entropy_fold(chan_i, row_i[HASH_ROW_MIN-1:0], bank_i[HASH_BANK_W-1:0]);
      default:     mode_bad = 1'b1;
    endcase
  end

  assign mode_err_o  = mode_bad;
  assign range_err_o = !mode_bad && ({1'b0, cand} >= CHAN_LIM);
  assign chan_o      = (mode_err_o || range_err_o) ? chan_i : cand;

endmodule

// File: rtl/chan_subpart_form.sv
module chan_subpart_form
  import chan_hash_pkg::*;
#(
  parameter int SUBP_PER_CHAN = 2,
  parameter int BANK_W        = 4,
  localparam int SUBP_LOG     = $clog2(SUBP_PER_CHAN),
  localparam int SUBP_W       = CH_W + SUBP_LOG
) (
  input  logic [CH_W-1:0]   chan_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [SUBP_W-1:0] subp_o
);

  generate
    if (SUBP_LOG == 0) begin : g_one_subp
      assign subp_o = chan_i;
    end else begin : g_multi_subp
      assign subp_o = {chan_i, bank_i[SUBP_LOG-1:0]};
    end
  endgenerate

endmodule

// File: rtl/chan_hash_unit.sv
module chan_hash_unit
  import chan_hash_pkg::*;
#(
  parameter int NUM_CHAN      = 32,
  parameter int SUBP_PER_CHAN = 2,
  parameter int ROW_W         = 15,
  parameter int BANK_W        = 4,
  localparam int SUBP_W       = CH_W + $clog2(SUBP_PER_CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [SUBP_W-1:0] subp_o,
  output logic              err_o
);

  logic [CH_W-1:0]   chan_next;
  logic [SUBP_W-1:0] subp_next;
  logic              mode_err;
  logic              range_err;
  logic              hash_err;

  chan_hash_mix #(
    .NUM_CHAN (NUM_CHAN),
    .ROW_W    (ROW_W),
    .BANK_W   (BANK_W)
  ) u_mix (
    .mode_i      (mode_i),
    .chan_i      (chan_i),
    .row_i       (row_i),
    .bank_i      (bank_i),
    .chan_o      (chan_next),
    .mode_err_o  (mode_err),
    .range_err_o (range_err)
  );

  chan_subpart_form #(
    .SUBP_PER_CHAN (SUBP_PER_CHAN),
    .BANK_W        (BANK_W)
  ) u_subp (
    .chan_i (chan_next),
    .bank_i (bank_i),
    .subp_o (subp_next)
  );

  assign hash_err = mode_err | range_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      chan_o  <= '0;
      subp_o  <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & hash_err;
      if (valid_i) begin
        chan_o <= chan_next;
        subp_o <= subp_next;
      end
    end
  end

endmodule

// File: rtl/chan_hash_chk.sv
module chan_hash_chk
  import chan_hash_pkg::*;
#(
  parameter int NUM_CHAN      = 32,
  parameter int SUBP_PER_CHAN = 2,
  parameter int BANK_W        = 4,
  localparam int SUBP_LOG     = $clog2(SUBP_PER_CHAN),
  localparam int SUBP_W       = CH_W + SUBP_LOG
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [2:0]        mode_i,
  input logic [CH_W-1:0]   chan_i,
  input logic [BANK_W-1:0] bank_i,
  input logic              valid_o,
  input logic [CH_W-1:0]   chan_o,
  input logic [SUBP_W-1:0] subp_o,
  input logic              err_o,
  input logic              mode_err,
  input logic              range_err
);

  localparam logic [CH_W:0] LIM = (CH_W+1)'(NUM_CHAN);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);  // R2
  AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> valid_o);  // R2
  AST_STRAIGHT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (mode_i == 3'd0 || mode_i == 3'd3) && !range_err) |=> (chan_o == $past(chan_i)));  // R3
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_i > 3'd4) |=> (err_o && chan_o == $past(chan_i)));  // R8
  AST_FUNC_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mode_err) |=> (err_o && chan_o == $past(chan_i)));  // R6
  AST_RANGE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && range_err) |=> (err_o && chan_o == $past(chan_i)));  // R9
  AST_CHAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o) |-> ({1'b0, chan_o} < LIM));  // R9
  AST_SUBP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((subp_o >> SUBP_LOG) == SUBP_W'(chan_o)));  // R10
  AST_SUBP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ((int'(subp_o) % SUBP_PER_CHAN) == (int'($past(bank_i)) % SUBP_PER_CHAN)));  // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(chan_o) && $stable(subp_o) && !err_o));  // R11

endmodule

bind chan_hash_unit chan_hash_chk #(
  .NUM_CHAN      (NUM_CHAN),
  .SUBP_PER_CHAN (SUBP_PER_CHAN),
  .BANK_W        (BANK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .chan_i    (chan_i),
  .bank_i    (bank_i),
  .valid_o   (valid_o),
  .chan_o    (chan_o),
  .subp_o    (subp_o),
  .err_o     (err_o),
  .mode_err  (mode_err),
  .range_err (range_err)
);

// File: tb/tb_chan_hash_unit.sv
`timescale 1ns/1ps
module tb_chan_hash_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [4:0]  chan_i = '0;
  logic [14:0] row_i = '0;
  logic [3:0]  bank_i = '0;

  logic        v_a, e_a, v_b, e_b;
  logic [4:0]  c_a, c_b;
  logic [5:0]  s_a, s_b;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  chan_hash_unit dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .chan_i(chan_i), .row_i(row_i), .bank_i(bank_i),
    .valid_o(v_a), .chan_o(c_a), .subp_o(s_a), .err_o(e_a)
  );

  chan_hash_unit #(.NUM_CHAN(16)) dut_small (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .chan_i(chan_i), .row_i(row_i), .bank_i(bank_i),
    .valid_o(v_b), .chan_o(c_b), .subp_o(s_b), .err_o(e_b)
  );

  // Tap masks restated from R5 and R7 as bit sets.
  localparam logic [14:0] POLY_M [5] = '{15'h3E69, 15'h7CD2, 15'h47CD, 15'h0F9A, 15'h1F34};
  localparam logic [14:0] ENT_RM [5] = '{15'h2621, 15'h1842, 15'h4384, 15'h0D08, 15'h1330};
  localparam logic [3:0]  ENT_BM [5] = '{4'h9, 4'hE, 4'h2, 4'hC, 4'h3};

  // Stimulus: {mode, chan, row, bank}
  localparam int NV = 16;
  localparam logic [26:0] VEC [NV] = '{
    {3'd0, 5'd7,  15'h1234, 4'h5},
    {3'd3, 5'd19, 15'h7FFF, 4'hF},
    {3'd1, 5'd10, 15'h0015, 4'h3},
    {3'd1, 5'd31, 15'h5A5A, 4'h0},
    {3'd1, 5'd3,  15'h7FE5, 4'h1},
    {3'd2, 5'd0,  15'h0001, 4'h0},
    {3'd2, 5'd0,  15'h4000, 4'h0},
    {3'd2, 5'd21, 15'h6B3C, 4'h9},
    {3'd4, 5'd0,  15'h0000, 4'h8},
    {3'd4, 5'd12, 15'h2A71, 4'h6},
    {3'd4, 5'd0,  15'h0001, 4'h0},
    {3'd4, 5'd0,  15'h0000, 4'h2},
    {3'd5, 5'd17, 15'h7FFF, 4'h1},
    {3'd6, 5'd30, 15'h0000, 4'h7},
    {3'd7, 5'd2,  15'h0001, 4'h2},
    {3'd0, 5'd20, 15'h0000, 4'h3}
  };

  // Returns {err, channel} per R3..R9.
  function automatic logic [5:0] model(input logic [2:0] m, input logic [4:0] c,
                                       input logic [14:0] r, input logic [3:0] b,
                                       input int nch);
    logic [4:0] cand;
    logic bad;
    bad = 1'b0;
    cand = c;
    if (m == 3'd1) cand = c ^ (r[4:0] & 5'(nch - 1));
    else if (m == 3'd2) begin
      if (nch != 32) bad = 1'b1;
      else for (int k = 0; k < 5; k++) cand[k] = c[k] ^ (^(r & POLY_M[k]));
    end else if (m == 3'd4) begin
      for (int k = 0; k < 5; k++) cand[k] = c[k] ^ (^(r & ENT_RM[k])) ^ (^(b & ENT_BM[k]));
    end else if (m > 3'd4) bad = 1'b1;
    if (!bad && int'(cand) >= nch) bad = 1'b1;
    return {bad, bad ? c : cand};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_one(input string tag, input logic [5:0] e, input logic [3:0] b,
                           input logic v, input logic [4:0] c, input logic [5:0] s,
                           input logic er);
    string rq;
    rq = tag;
    chk("R2",  {tag, " valid_o"}, int'(v), 1);
    chk(rq,    {tag, " chan_o"}, int'(c), int'(e[4:0]));
    chk(rq,    {tag, " err_o"}, int'(er), int'(e[5]));
    chk("R10", {tag, " subp_o"}, int'(s), int'(e[4:0]) * 2 + int'(b[0]));
  endtask

  function automatic string req_of(input logic [2:0] m, input logic err);
    if (m > 3'd4) return "R8";
    if (m == 3'd2 && err) return "R6";
    if (err) return "R9";
    case (m)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd4: return "R7";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0] ea, eb;
    logic [4:0] held_c;
    logic [5:0] held_s;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "valid_o", int'(v_a), 0);
    chk("R1", "err_o", int'(e_a), 0);
    chk("R1", "chan_o", int'(c_a), 0);
    chk("R1", "subp_o", int'(s_a), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {mode_i, chan_i, row_i, bank_i} = VEC[i];
      valid_i = 1'b1;
      ea = model(mode_i, chan_i, row_i, bank_i, 32);
      eb = model(mode_i, chan_i, row_i, bank_i, 16);
      @(negedge clk);
      valid_i = 1'b0;
      check_one(req_of(VEC[i][26:24], ea[5]), ea, VEC[i][3:0], v_a, c_a, s_a, e_a);
      check_one(req_of(VEC[i][26:24], eb[5]), eb, VEC[i][3:0], v_b, c_b, s_b, e_b);
    end

    // R11: idle cycles with changed inputs leave the outputs untouched
    held_c = c_a;
    held_s = s_a;
    mode_i = 3'd1; chan_i = 5'd9; row_i = 15'h7FFF; bank_i = 4'hF;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "idle chan_o", int'(c_a), int'(held_c));
    chk("R11", "idle subp_o", int'(s_a), int'(held_s));
    chk("R11", "idle err_o", int'(e_a), 0);
    chk("R2",  "idle valid_o", int'(v_a), 0);

    // R2: back-to-back requests, one result per cycle
    mode_i = 3'd0; chan_i = 5'd5; bank_i = 4'h1; valid_i = 1'b1;
    @(negedge clk);
    chk("R2", "stream first", int'(c_a), 5);
    mode_i = 3'd7; chan_i = 5'd6;
    @(negedge clk);
    chk("R2", "stream second valid_o", int'(v_a), 1);
    chk("R8", "stream second err_o", int'(e_a), 1);
    valid_i = 1'b0;
    @(negedge clk);
    chk("R2", "stream end err_o", int'(e_a), 0);

    // R1: reset in mid-run clears everything
    mode_i = 3'd0; chan_i = 5'd27; valid_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    valid_i = 1'b0;
    #1;
    chk("R1", "mid reset chan_o", int'(c_a), 0);
    chk("R1", "mid reset valid_o", int'(v_a), 0);
    chk("R1", "mid reset subp_o", int'(s_a), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule